// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address Filter and Line-Driver Enable

This block is a full-duplex asynchronous serial port for a byte-wide register bus. Each character on the wire begins with a low start bit, carries eight data bits with the least significant bit first, has an optional ninth bit, and ends with one high stop bit. The ninth bit is either a parity bit or, in multidrop mode, an address/data marker. The line rests high. A 16-bit divisor drives an oversampling tick at sixteen ticks per bit. The receiver uses that tick to find the middle of each bit. The transmitter uses it to time every bit exactly.

For half-duplex bus transceivers, the block raises a driver-enable output ahead of the start bit and holds it through the stop bit. An active-low clear-to-send input can hold back new characters. In multidrop mode a node ignores traffic until it sees its own address byte. It then accepts that address and all data after it, and stops accepting at the next address byte that does not match. A single interrupt output combines the receive, transmit and divisor-reload events. The divisor keeps running when both directions are off, so it can also serve as a periodic timer.

Registers, by 3-bit address: 0 data (a write loads the transmit holding register, a read returns the received byte), 1 status (read only), 2 control A, 3 control B, 4 station address, 5 divisor high byte, 6 divisor low byte, 7 auxiliary (read only).

Top module: `uart_addr_de`

## Requirements
- R1: After reset, txd is 1, de and irq are 0, status (address 1) reads 0xE0 while cts_n is low (bit7 clear-to-send level, bit6 transmitter idle, bit5 holding register empty, bit4 receive full, bit3 parity error, bit2 framing error, bit1 overrun, bit0 new frame), control A reads 0 and the divisor low byte reads the RST_DIV default of 4.
- R2: With control A bit7 (transmit enable) set, a byte written to address 0 leaves txd as a 0 start bit, eight data bits LSB first, a ninth bit when control A bit4 (parity enable) is set, and a 1 stop bit. The ninth bit is the XOR of the data bits, inverted when control A bit3 (odd parity) is set.
- R3: With control A bit2 (driver enable mode) set, de rises between one and two bit periods before the start bit falls, and stays high until the stop bit ends.
- R4: With control A bit5 (flow control) set, no character starts while cts_n is high, and the holding register stays full. With bit5 clear, cts_n has no effect.
- R5: With control A bit6 (receive enable) set, a received byte appears at address 0, with status bit4 and bit0 set and bit3 set on a wrong parity bit. Reading address 0 clears bits 4, 3, 2, 1 and 0 of the status.
- R6: A stop bit sampled low sets status bit2 (framing error) together with the byte.
- R7: A byte that completes while status bit4 is still set is discarded, the stored byte is kept, and status bit1 (overrun) is set.
- R8: A low pulse on rxd that is high again at the middle of the start bit is ignored: no byte and no new-frame flag follow.
- R9: With control B bit0 (multidrop) set, the ninth bit marks an address when 1. An address byte equal to address 4 is accepted and arms the filter, shown in auxiliary bit0. Data bytes are accepted only while the filter is armed, and an address byte that does not match disarms it and is dropped. Control B bit2 gives the ninth bit that is sent.
- R10: With control A bit0 set, irq is high whenever the transmit holding register is empty.
- R11: The divisor reload sets auxiliary bit1, whether or not the transmitter and receiver are enabled. With control B bit1 set, that bit drives irq, and reading address 7 clears it. Successive reloads are a divisor apart.
- R12: One bit on txd lasts exactly 16 times the divisor in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on the cycle it is high) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| de | output | 1 | Line-driver enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench goes after the cases where a timing slip or a wrong flag stays hidden in normal traffic. It measures the exact width of a bit and the lead of de over the start bit: a sequencer that started mid-tick would fall short of a full bit of lead. It replays a stop bit held low, two bytes without a read in between, and a short glitch, where a careless receiver would corrupt the held byte or build a frame from noise. It walks the multidrop filter through a foreign address, its own address, data after it, and a second foreign address that must close the filter, where a wrong design would keep passing data. It also holds back a character with clear-to-send and times the divisor as a bare timer.

// File: rtl/uart_addr_de.sv
module uart_addr_de #(
  parameter int          ADDR_W  = 3,
  parameter logic [15:0] RST_DIV = 16'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              rxd,
  output logic              txd,
  input  logic              cts_n,
  output logic              de,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(7);
  localparam logic [3:0]        SUB_LAST = 4'd15;
  localparam logic [3:0]        SUB_MID  = 4'd7;

  typedef enum logic [2:0] {T_IDLE, T_LEAD, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_t;

  logic [7:0]  ctla, station;
  logic [2:0]  ctlb;
  logic [15:0] div, brg_cnt;
  logic        brg_tick, brg_evt;

  wire ten     = ctla[7];
  wire ren     = ctla[6];
  wire cts_en  = ctla[5];
  wire par_en  = ctla[4];
  wire par_odd = ctla[3];
  wire de_en   = ctla[2];
  wire mp_en   = ctlb[0];
  wire has9    = par_en | mp_en;

  wire wr_data = wr_en && addr == A_DATA;
  wire rd_data = rd_en && addr == A_DATA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctla <= '0; ctlb <= '0; station <= '0; div <= RST_DIV;
    end else if (wr_en) begin
      case (addr)
        A_CTLA: ctla <= wdata;
        A_CTLB: ctlb <= wdata[2:0];
        A_ADDR: station <= wdata;
        A_DIVH: div[15:8] <= wdata;
        A_DIVL: div[7:0] <= wdata;
        default: ;
      endcase
    end
  end

  assign brg_tick = (div != '0) && (brg_cnt <= 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brg_cnt <= RST_DIV;
      brg_evt <= 1'b0;
    end else begin
      brg_cnt <= (brg_cnt <= 16'd1) ? div : brg_cnt - 16'd1;
      if (rd_en && addr == A_AUX) brg_evt <= 1'b0;
      if (brg_tick) brg_evt <= 1'b1;
    end
  end

  logic [1:0] cts_s, rx_s;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_s <= 2'b11; rx_s <= 2'b11;
    end else begin
      cts_s <= {cts_s[0], cts_n}; rx_s <= {rx_s[0], rxd};
    end
  end
  wire cts_ok = !cts_s[1] || !cts_en;
  wire rxi    = rx_s[1];

  tx_st_t     tst;
  logic [7:0] thold, tsh;
  logic       tdre, t9;
  logic [3:0] tsub;
  logic [2:0] tbit;
  logic       tx_busy;
  assign tx_busy = tst != T_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tst <= T_IDLE; thold <= '0; tsh <= '0; tdre <= 1'b1;
      t9 <= 1'b0; tsub <= '0; tbit <= '0;
    end else begin
      if (tst == T_IDLE) begin
        if (ten && !tdre && cts_ok && brg_tick) begin
          tsh  <= thold;
          t9   <= mp_en ? ctlb[2] : (par_odd ^ (^thold));
          tdre <= 1'b1;
          tsub <= '0;
          tst  <= de_en ? T_LEAD : T_START;
        end
      end else if (brg_tick) begin
        tsub <= tsub + 4'd1;
        if (tsub == SUB_LAST) begin
          case (tst)
            T_LEAD:  tst <= T_START;
            T_START: begin tst <= T_DATA; tbit <= '0; end
            T_DATA: begin
              tsh  <= tsh >> 1;
              tbit <= tbit + 3'd1;
              if (tbit == 3'd7) tst <= has9 ? T_PAR : T_STOP;
            end
            T_PAR:   tst <= T_STOP;
            default: tst <= T_IDLE;
          endcase
        end
      end
      if (wr_data) begin thold <= wdata; tdre <= 1'b0; end
    end
  end

  always_comb begin
    case (tst)
      T_START: txd = 1'b0;
      T_DATA:  txd = tsh[0];
      T_PAR:   txd = t9;
      default: txd = 1'b1;
    endcase
  end
  assign de = de_en && tx_busy;

  rx_st_t     rst_q;
  logic [7:0] rsh, rbuf;
  logic       r9, rdrf, pe, fe, oe, newfrm, matched;
  logic [3:0] rsub;
  logic [2:0] rbit;

  wire par_bad = par_en && !mp_en && (r9 != (par_odd ^ (^rsh)));
  wire is_addr = mp_en && r9;
  wire accept  = !mp_en || (r9 ? (rsh == station) : matched);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q <= R_IDLE; rsh <= '0; rbuf <= '0; r9 <= 1'b0; rdrf <= 1'b0;
      pe <= 1'b0; fe <= 1'b0; oe <= 1'b0; newfrm <= 1'b0; matched <= 1'b0;
      rsub <= '0; rbit <= '0;
    end else begin
      if (rd_data) begin
        rdrf <= 1'b0; pe <= 1'b0; fe <= 1'b0; oe <= 1'b0; newfrm <= 1'b0;
      end
      if (!ren) rst_q <= R_IDLE;
      else if (brg_tick) begin
        rsub <= rsub + 4'd1;
        case (rst_q)
          R_IDLE: if (!rxi) begin rst_q <= R_START; rsub <= '0; end
          R_START: if (rsub == SUB_MID) begin
            if (rxi) rst_q <= R_IDLE;
            else begin newfrm <= 1'b1; rsub <= '0; rbit <= '0; rst_q <= R_DATA; end
          end
          R_DATA: if (rsub == SUB_LAST) begin
            rsh  <= {rxi, rsh[7:1]};
            rsub <= '0;
            rbit <= rbit + 3'd1;
            if (rbit == 3'd7) rst_q <= has9 ? R_PAR : R_STOP;
          end
          R_PAR: if (rsub == SUB_LAST) begin r9 <= rxi; rsub <= '0; rst_q <= R_STOP; end
          default: if (rsub == SUB_LAST) begin
            rst_q <= R_IDLE;
            if (is_addr) matched <= (rsh == station);
            if (accept) begin
              if (rdrf) oe <= 1'b1;
              else begin
                rbuf <= rsh; rdrf <= 1'b1; pe <= par_bad; fe <= !rxi;
              end
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = rbuf;
      A_STAT:  rdata = {!cts_s[1], !tx_busy && tdre, tdre, rdrf, pe, fe, oe, newfrm};
      A_CTLA:  rdata = ctla;
      A_CTLB:  rdata = {5'b0, ctlb};
      A_ADDR:  rdata = station;
      A_DIVH:  rdata = div[15:8];
      A_DIVL:  rdata = div[7:0];
      default: rdata = {6'b0, brg_evt, matched};
    endcase
  end

  assign irq = (ctla[1] && (rdrf || pe || fe || oe)) || (ctla[0] && tdre) || (ctlb[1] && brg_evt);
endmodule

module uart_addr_de_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       de,
  input logic       irq,
  input logic       de_en,
  input logic       cts_en,
  input logic       cts_ok,
  input logic       tx_busy,
  input logic       tx_irq_en,
  input logic       tdre,
  input logic       oe,
  input logic [7:0] rbuf
);
  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  p_de_leads_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && de_en) |-> $past(de));
  p_cts_holds_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cts_en && !cts_ok) |=> !tx_busy);
  p_overrun_keeps_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $stable(rbuf));
  p_tx_empty_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq_en && tdre) |-> irq);
endmodule

bind uart_addr_de uart_addr_de_chk i_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .de(de), .irq(irq),
  .de_en(ctla[2]), .cts_en(ctla[5]), .cts_ok(cts_ok), .tx_busy(tx_busy),
  .tx_irq_en(ctla[0]), .tdre(tdre), .oe(oe), .rbuf(rbuf)
);

// File: tb/test_uart_addr_de.sv
module test_uart_addr_de;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int BP  = 16 * DIV;
  localparam int TDIV = 40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       rxd = 1'b1, txd, cts_n = 1'b0, de, irq;
  int         nrun = 0, nfail = 0, cyc = 0;

  uart_addr_de i_uart_addr_de (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .cts_n(cts_n),
    .de(de), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  endtask

  function automatic bit pbit(input logic [7:0] b, input bit odd);
    return odd ^ (^b);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit has9, input bit b9, input bit stopv);
    @(negedge clk); rxd = 1'b0; repeat (BP) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BP) @(negedge clk); end
    if (has9) begin rxd = b9; repeat (BP) @(negedge clk); end
    rxd = stopv; repeat (BP) @(negedge clk);
    rxd = 1'b1; repeat (BP) @(negedge clk);
  endtask

  task automatic recv_tx(input bit has9, output logic [7:0] b, output bit b9, output bit stopv);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BP/2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin repeat (BP) @(negedge clk); b[i] = txd; end
    b9 = 1'b0;
    if (has9) begin repeat (BP) @(negedge clk); b9 = txd; end
    repeat (BP) @(negedge clk); stopv = txd;
    repeat (BP/2 + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    report();
  end

  initial begin
    logic [7:0] s, d, b;
    bit b9, st, stay, pe_en, odd, bad;
    int cnt, t0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(de === 1'b0 && irq === 1'b0, "R1 de/irq", {de, irq}, 0);
    rd(3'd1, s); check(s == 8'hE0, "R1 status", s, 8'hE0);
    rd(3'd2, s); check(s == 8'h00, "R1 control A", s, 0);
    rd(3'd6, s); check(s == 8'h04, "R1 divisor", s, 4);

    wr(3'd5, 8'h00); wr(3'd6, DIV[7:0]); wr(3'd4, 8'h5A);

    // R12 bit period
    wr(3'd2, 8'h80); wr(3'd0, 8'h00);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    cnt = 0;
    while (txd === 1'b0) begin cnt++; @(negedge clk); end
    check(cnt == 9 * BP, "R12 low time of 0x00", cnt, 9 * BP);
    repeat (2 * BP) @(negedge clk);

    // R2 / R5 random traffic
    for (int i = 0; i < 12; i++) begin
      b = 8'($urandom);
      cnt = int'($urandom % 3);
      pe_en = cnt != 0; odd = cnt == 2;
      wr(3'd2, 8'hC0 | (8'(pe_en) << 4) | (8'(odd) << 3));
      wr(3'd0, b);
      recv_tx(pe_en, d, b9, st);
      check(d == b, "R2 tx data", d, b);
      if (pe_en) check(b9 == pbit(b, odd), "R2 tx parity", b9, pbit(b, odd));
      check(st == 1'b1, "R2 tx stop", st, 1);
      bad = pe_en && ($urandom % 4 == 0);
      send_rx(b, pe_en, pbit(b, odd) ^ bad, 1'b1);
      rd(3'd1, s);
      check(s[4] && s[0], "R5 full and new frame", s, 8'h11);
      check(s[3] == bad, "R5 parity error", s[3], bad);
      rd(3'd0, d); check(d == b, "R5 rx data", d, b);
      rd(3'd1, s); check(s[4:0] == 5'b0, "R5 read clears flags", s[4:0], 0);
    end

    // R3 driver enable lead and hold
    wr(3'd2, 8'h84); wr(3'd0, 8'h3C);
    @(negedge clk);
    while (de !== 1'b1) @(negedge clk);
    cnt = 0;
    while (txd === 1'b1) begin cnt++; @(negedge clk); end
    check(cnt >= BP && cnt <= 2 * BP, "R3 de lead", cnt, BP);
    cnt = 0;
    while (de === 1'b1) begin cnt++; @(negedge clk); end
    check(cnt == 10 * BP, "R3 de hold to end of stop", cnt, 10 * BP);
    repeat (BP) @(negedge clk);

    // R4 clear to send
    wr(3'd2, 8'hA0); cts_n = 1'b1; repeat (4) @(negedge clk);
    wr(3'd0, 8'h96);
    stay = 1'b1;
    repeat (3 * BP) begin @(negedge clk); if (txd !== 1'b1) stay = 1'b0; end
    check(stay, "R4 held back by cts", stay, 1);
    rd(3'd1, s); check(s[5] == 1'b0 && s[7] == 1'b0, "R4 holding full, cts level", s[7:5], 0);
    cts_n = 1'b0;
    recv_tx(1'b0, d, b9, st); check(d == 8'h96, "R4 sent after cts", d, 8'h96);
    wr(3'd2, 8'h80); cts_n = 1'b1; repeat (4) @(negedge clk);
    wr(3'd0, 8'h69);
    recv_tx(1'b0, d, b9, st); check(d == 8'h69, "R4 cts ignored when off", d, 8'h69);
    cts_n = 1'b0;

    // R10 transmit interrupt
    wr(3'd2, 8'h01); @(negedge clk);
    check(irq === 1'b1, "R10 irq on empty", irq, 1);
    wr(3'd0, 8'h55); @(negedge clk);
    check(irq === 1'b0, "R10 irq off when full", irq, 0);
    wr(3'd2, 8'h81); repeat (2 * DIV + 2) @(negedge clk);
    check(irq === 1'b1, "R10 irq after load", irq, 1);
    recv_tx(1'b0, d, b9, st); check(d == 8'h55, "R10 byte sent", d, 8'h55);
    wr(3'd2, 8'h00);

    // R7 overrun
    wr(3'd2, 8'h40);
    send_rx(8'hA1, 1'b0, 1'b0, 1'b1);
    send_rx(8'hB2, 1'b0, 1'b0, 1'b1);
    rd(3'd1, s); check(s[1] && s[4], "R7 overrun flag", s, 8'h12);
    rd(3'd0, d); check(d == 8'hA1, "R7 first byte kept", d, 8'hA1);
    rd(3'd1, s); check(s[1] == 1'b0, "R7 overrun cleared", s[1], 0);

    // R6 framing error
    send_rx(8'hC3, 1'b0, 1'b0, 1'b0);
    repeat (BP) @(negedge clk);
    rd(3'd1, s); check(s[2] && s[4], "R6 framing error", s, 8'h14);
    rd(3'd0, d); check(d == 8'hC3, "R6 byte with error", d, 8'hC3);
    rd(3'd1, s); check(s[4:0] == 5'b0, "R6 cleared", s[4:0], 0);

    // R8 glitch rejection
    @(negedge clk); rxd = 1'b0; repeat (4 * DIV) @(negedge clk); rxd = 1'b1;
    repeat (2 * BP) @(negedge clk);
    rd(3'd1, s); check(s[4:0] == 5'b0, "R8 glitch ignored", s[4:0], 0);
    send_rx(8'h5E, 1'b0, 1'b0, 1'b1);
    rd(3'd0, d); check(d == 8'h5E, "R8 frame after glitch", d, 8'h5E);

    // R9 multidrop filter
    wr(3'd3, 8'h01);
    send_rx(8'h11, 1'b1, 1'b0, 1'b1);
    rd(3'd1, s); check(s[4] == 1'b0, "R9 data before address dropped", s[4], 0);
    send_rx(8'h33, 1'b1, 1'b1, 1'b1);
    rd(3'd1, s); check(s[4] == 1'b0, "R9 foreign address dropped", s[4], 0);
    send_rx(8'h5A, 1'b1, 1'b1, 1'b1);
    rd(3'd1, s); check(s[4] == 1'b1, "R9 own address accepted", s[4], 1);
    rd(3'd0, d); check(d == 8'h5A, "R9 address byte", d, 8'h5A);
    rd(3'd7, s); check(s[0] == 1'b1, "R9 filter armed", s[0], 1);
    send_rx(8'h77, 1'b1, 1'b0, 1'b1);
    rd(3'd0, d); check(d == 8'h77, "R9 data after match", d, 8'h77);
    send_rx(8'h44, 1'b1, 1'b1, 1'b1);
    send_rx(8'h88, 1'b1, 1'b0, 1'b1);
    rd(3'd1, s); check(s[4] == 1'b0, "R9 filter closed", s[4], 0);
    rd(3'd7, s); check(s[0] == 1'b0, "R9 filter disarmed", s[0], 0);
    wr(3'd3, 8'h05); wr(3'd2, 8'h80); wr(3'd0, 8'hA5);
    recv_tx(1'b1, d, b9, st);
    check(d == 8'hA5 && b9 == 1'b1, "R9 sent address marker", {b9, d}, 9'h1A5);

    // R11 divisor as timer with both directions off
    wr(3'd2, 8'h00); wr(3'd6, TDIV[7:0]); wr(3'd3, 8'h02);
    rd(3'd7, s);
    cnt = 0;
    while (irq !== 1'b1 && cnt < 2 * TDIV) begin cnt++; @(negedge clk); end
    check(cnt <= TDIV, "R11 first reload", cnt, TDIV);
    t0 = cyc;
    rd(3'd7, s); check(s[1] == 1'b1, "R11 reload flag", s[1], 1);
    check(irq === 1'b0, "R11 flag cleared by read", irq, 0);
    while (irq !== 1'b1) @(negedge clk);
    check(cyc - t0 == TDIV, "R11 reload interval", cyc - t0, TDIV);
    wr(3'd3, 8'h00); wr(3'd6, DIV[7:0]);

    report();
  end
endmodule